// File: doc/BRIEF.md
# Pulse-Pause Frame Receiver

This block recovers the bits of a reader-to-card frame that is sent with pulse-pause coding. The carrier envelope arrives as an asynchronous level, where low means the reader has paused the carrier. The block brings that level into the clock domain, samples it once per enable of a 212 kHz tick, and timestamps each pause start against a free-running tick count. The distance between two successive pause starts is one bit: a long distance is a one, a short distance is a zero, and a distance that breaks the coding rules ends the frame. The coding has no explicit end marker, so the frame closes on that rule break.

A one-cycle `arm` pulse starts a reception. The block then waits for the first pause. While it waits, it steps an external keystream generator once at arming and once more for every full one-bit period that passes. Each decoded bit is XORed with the generator's current output and stored by index, and the generator is stepped again. When the frame closes, the block raises a valid or error pulse. It holds the bit count, the descrambled payload and an end-of-frame timestamp until the next accepted `arm`.

Top module: `ppr_frame_rx`

## Requirements
- R1: After reset, `frame_valid`, `frame_error` and `ks_adv` are 0, and `frame_len`, `frame_data` and `end_ts` are 0.
- R2: Every tick enable is stamped with its index, counted from 0 after reset. A bit's length L is the stamp difference between successive pause starts, where a pause start is a tick that samples the envelope low after a high sample. L greater than 17 decodes as 1, and L from 4 to 17 decodes as 0.
- R3: A next pause that starts with L below 4 is a code violation and ends the frame. The end timestamp then refers to that new pause.
- R4: If the pause has not ended, or the next pause has not started, by L = 31, the frame ends on the tick where L reaches 32. L = 31 is still accepted as a bit.
- R5: A frame that ends with 6 to 23 decoded bits gives `frame_valid`. Any other count gives `frame_error`.
- R6: Decoded bit j is stored at `frame_data[j]` as its value XOR `ks_bit`, where `ks_bit` is the value present in the decoding cycle. `ks_adv` pulses exactly once per decoded bit.
- R7: An accepted `arm` pulses `ks_adv` once. While no pause has been seen, `ks_adv` pulses once more at the end of each further 21 ticks. If the 40th such period expires with no pause, the block gives `frame_error` with `frame_len` 0, after 40 advances in total.
- R8: `end_ts` equals the stamp of the frame's last pause start plus 2. This is the pause length of 4 minus 2 ticks of pipeline compensation.
- R9: `frame_valid` and `frame_error` are single-cycle pulses, and the results stay held until the next accepted `arm`. An accepted `arm` clears them. An `arm` during a reception is ignored.
- R10: `frame_len` counts decoded bits and saturates at 24. Bits after the 23rd are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_in | input | 1 | Asynchronous envelope level, low during a pause |
| tick | input | 1 | 212 kHz tick enable, one clock wide |
| arm | input | 1 | Start a reception (honoured only when idle) |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Step the keystream generator |
| frame_valid | output | 1 | Frame accepted pulse |
| frame_error | output | 1 | Frame rejected or no frame pulse |
| frame_len | output | 5 | Decoded bit count, saturating at 24 |
| frame_data | output | 23 | Descrambled payload, first bit in bit 0 |
| end_ts | output | 32 | End-of-frame timestamp in ticks |

## Verification
A level driven on `env_in` passes through two synchronizer flops, so the bench changes it three clocks before the tick that must sample it. `ks_adv` is combinational and acts in the same cycle as the decode or the `arm`. The frame outcome registers at the closing tick's edge and is sampled just after that edge, on the step whose tick index is predicted: 32 ticks after the last pause start for a timeout, or the violating pause itself for a short bit. The bench then samples one clock later to confirm the pulse has dropped, and samples again after further ticks to confirm the results are held. It counts keystream steps at the port, so the hunt and per-bit advance counts are checked against the arithmetic in R6 and R7.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int unsigned PAUSE_TICKS_D  = 4;
    localparam int unsigned ONE_TICKS_D    = 21;
    localparam int unsigned ZERO_TICKS_D   = 13;
    localparam int unsigned HUNT_PERIODS_D = 40;
    localparam int unsigned MIN_BITS_D     = 6;
    localparam int unsigned MAX_BITS_D     = 23;
    localparam int unsigned PIPE_COMP_D    = 2;
    localparam int unsigned TS_W_D         = 32;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HUNT,
        RX_PAUSE,
        RX_PULSE
    } rx_state_e;

    typedef struct packed {
        logic start;      // arm accepted
        logic adv;        // hunt-phase keystream step
        logic bit_vld;    // one bit decoded
        logic bit_val;
        logic frame_end;  // code violation closed the frame
        logic hunt_fail;  // no first pause in time
    } slice_evt_t;

    function automatic logic slice_bit(input int unsigned len, input int unsigned thr);
        return len > thr;
    endfunction

endpackage

// File: rtl/ppr_sync.sv
module ppr_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic env_async,
    output logic env_s
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= env_async;
            sync_q <= meta_q;
        end
    end

    assign env_s = sync_q;
endmodule

// File: rtl/ppr_slicer.sv
module ppr_slicer
    import ppr_pkg::*;
#(
    parameter int unsigned TS_W         = TS_W_D,
    parameter int unsigned PAUSE_TICKS  = PAUSE_TICKS_D,
    parameter int unsigned ONE_TICKS    = ONE_TICKS_D,
    parameter int unsigned ZERO_TICKS   = ZERO_TICKS_D,
    parameter int unsigned HUNT_PERIODS = HUNT_PERIODS_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            arm,
    input  logic            env_s,
    input  logic [TS_W-1:0] now,
    output slice_evt_t      evt,
    output logic [TS_W-1:0] last_pause
);
    localparam int unsigned THRESH = (ZERO_TICKS + ONE_TICKS) / 2;
    localparam int unsigned LIMIT  = (ONE_TICKS * 3) / 2;
    localparam int unsigned EL_W   = $clog2(LIMIT + 2);
    localparam int unsigned HC_W   = $clog2(ONE_TICKS);
    localparam int unsigned PC_W   = $clog2(HUNT_PERIODS + 1);
    localparam logic [EL_W-1:0] LIMIT_L = EL_W'(LIMIT);
    localparam logic [EL_W-1:0] PAUSE_L = EL_W'(PAUSE_TICKS);

    rx_state_e       st_q, st_d;
    logic [EL_W-1:0] el_q, el_d, len_n;
    logic [HC_W-1:0] hc_q, hc_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [TS_W-1:0] bs_q, bs_d;

    assign len_n = el_q + EL_W'(1);

    always_comb begin
        st_d       = st_q;
        el_d       = el_q;
        hc_d       = hc_q;
        pc_d       = pc_q;
        bs_d       = bs_q;
        evt        = '0;
        last_pause = bs_q;
        unique case (st_q)
            RX_IDLE: if (arm) begin
                st_d      = RX_HUNT;
                hc_d      = '0;
                pc_d      = PC_W'(1);
                evt.start = 1'b1;
                evt.adv   = 1'b1;
            end
            RX_HUNT: if (tick) begin
                if (!env_s) begin
                    st_d = RX_PAUSE;
                    el_d = '0;
                    bs_d = now;
                end else if (hc_q == HC_W'(ONE_TICKS - 1)) begin
                    hc_d = '0;
                    if (pc_q == PC_W'(HUNT_PERIODS)) begin
                        evt.hunt_fail = 1'b1;
                        st_d          = RX_IDLE;
                    end else begin
                        pc_d    = pc_q + PC_W'(1);
                        evt.adv = 1'b1;
                    end
                end else begin
                    hc_d = hc_q + HC_W'(1);
                end
            end
            RX_PAUSE: if (tick) begin
                el_d = len_n;
                if (len_n > LIMIT_L) begin
                    evt.frame_end = 1'b1;
                    st_d          = RX_IDLE;
                end else if (env_s) begin
                    st_d = RX_PULSE;
                end
            end
            RX_PULSE: if (tick) begin
                el_d = len_n;
                if (len_n > LIMIT_L) begin
                    evt.frame_end = 1'b1;
                    st_d          = RX_IDLE;
                end else if (!env_s) begin
                    bs_d       = now;
                    el_d       = '0;
                    last_pause = now;
                    if (len_n < PAUSE_L) begin
                        evt.frame_end = 1'b1;
                        st_d          = RX_IDLE;
                    end else begin
                        evt.bit_vld = 1'b1;
                        evt.bit_val = slice_bit(32'(len_n), THRESH);
                        st_d        = RX_PAUSE;
                    end
                end
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RX_IDLE;
            el_q <= '0;
            hc_q <= '0;
            pc_q <= '0;
            bs_q <= '0;
        end else begin
            st_q <= st_d;
            el_q <= el_d;
            hc_q <= hc_d;
            pc_q <= pc_d;
            bs_q <= bs_d;
        end
    end

    // R4: elapsed count inside a bit never passes the window
    a_r4_elapsed_cap: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_PAUSE || st_q == RX_PULSE) |-> (el_q <= LIMIT_L));

    // R6: at most one kind of event per cycle
    a_r6_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.adv, evt.bit_vld, evt.frame_end, evt.hunt_fail}));

    // R7: hunt period counter stays within its range
    a_r7_hunt_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_HUNT) |-> (pc_q >= PC_W'(1) && pc_q <= PC_W'(HUNT_PERIODS)));

    // R9: arm without a tick during reception leaves the state alone
    a_r9_arm_busy: assert property (@(posedge clk) disable iff (rst)
        (arm && !tick && (st_q == RX_PAUSE || st_q == RX_PULSE)) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/ppr_assembler.sv
module ppr_assembler
    import ppr_pkg::*;
#(
    parameter int unsigned TS_W        = TS_W_D,
    parameter int unsigned MIN_BITS    = MIN_BITS_D,
    parameter int unsigned MAX_BITS    = MAX_BITS_D,
    parameter int unsigned PAUSE_TICKS = PAUSE_TICKS_D,
    parameter int unsigned PIPE_COMP   = PIPE_COMP_D,
    localparam int unsigned LEN_W      = $clog2(MAX_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  slice_evt_t          evt,
    input  logic                ks_bit,
    input  logic [TS_W-1:0]     last_pause,
    output logic                frame_valid,
    output logic                frame_error,
    output logic [LEN_W-1:0]    frame_len,
    output logic [MAX_BITS-1:0] frame_data,
    output logic [TS_W-1:0]     end_ts
);
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(MAX_BITS + 1);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_BITS);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BITS);
    localparam logic [TS_W-1:0]  ADJ_L = TS_W'(PAUSE_TICKS - PIPE_COMP);

    logic [LEN_W-1:0]    cnt_q;
    logic [MAX_BITS-1:0] data_q;
    logic [TS_W-1:0]     ts_q;
    logic                ok_q, bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            data_q <= '0;
            ts_q   <= '0;
            ok_q   <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            ok_q  <= 1'b0;
            bad_q <= 1'b0;
            if (evt.start) begin
                cnt_q  <= '0;
                data_q <= '0;
                ts_q   <= '0;
            end
            if (evt.bit_vld) begin
                for (int i = 0; i < int'(MAX_BITS); i++) begin
                    if (cnt_q == LEN_W'(i)) data_q[i] <= evt.bit_val ^ ks_bit;
                end
                if (cnt_q != CAP_L) cnt_q <= cnt_q + LEN_W'(1);
            end
            if (evt.frame_end) begin
                ts_q <= last_pause + ADJ_L;
                if (cnt_q >= MIN_L && cnt_q <= MAX_L) ok_q <= 1'b1;
                else                                  bad_q <= 1'b1;
            end
            if (evt.hunt_fail) bad_q <= 1'b1;
        end
    end

    assign frame_valid = ok_q;
    assign frame_error = bad_q;
    assign frame_len   = cnt_q;
    assign frame_data  = data_q;
    assign end_ts      = ts_q;

    // R5: an accepted frame has a legal length
    a_r5_valid_len: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame_len >= MIN_L && frame_len <= MAX_L));

    // R9: outcome pulses are exclusive and last one cycle
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_error));
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        (frame_valid || frame_error) |=> !(frame_valid || frame_error));

    // R10: the count never passes the saturation point
    a_r10_len_cap: assert property (@(posedge clk) disable iff (rst)
        frame_len <= CAP_L);
endmodule

// File: rtl/ppr_frame_rx.sv
module ppr_frame_rx
    import ppr_pkg::*;
#(
    parameter int unsigned TS_W         = TS_W_D,
    parameter int unsigned PAUSE_TICKS  = PAUSE_TICKS_D,
    parameter int unsigned ONE_TICKS    = ONE_TICKS_D,
    parameter int unsigned ZERO_TICKS   = ZERO_TICKS_D,
    parameter int unsigned HUNT_PERIODS = HUNT_PERIODS_D,
    parameter int unsigned MIN_BITS     = MIN_BITS_D,
    parameter int unsigned MAX_BITS     = MAX_BITS_D,
    parameter int unsigned PIPE_COMP    = PIPE_COMP_D,
    localparam int unsigned LEN_W       = $clog2(MAX_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                env_in,
    input  logic                tick,
    input  logic                arm,
    input  logic                ks_bit,
    output logic                ks_adv,
    output logic                frame_valid,
    output logic                frame_error,
    output logic [LEN_W-1:0]    frame_len,
    output logic [MAX_BITS-1:0] frame_data,
    output logic [TS_W-1:0]     end_ts
);
    logic            env_s;
    logic [TS_W-1:0] now_q;
    logic [TS_W-1:0] last_pause;
    slice_evt_t      evt;

    always_ff @(posedge clk) begin
        if (rst)       now_q <= '0;
        else if (tick) now_q <= now_q + TS_W'(1);
    end

    ppr_sync #(.RST_VAL(1'b1)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .env_async (env_in),
        .env_s     (env_s)
    );

    ppr_slicer #(
        .TS_W         (TS_W),
        .PAUSE_TICKS  (PAUSE_TICKS),
        .ONE_TICKS    (ONE_TICKS),
        .ZERO_TICKS   (ZERO_TICKS),
        .HUNT_PERIODS (HUNT_PERIODS)
    ) u_slicer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .arm        (arm),
        .env_s      (env_s),
        .now        (now_q),
        .evt        (evt),
        .last_pause (last_pause)
    );

    ppr_assembler #(
        .TS_W        (TS_W),
        .MIN_BITS    (MIN_BITS),
        .MAX_BITS    (MAX_BITS),
        .PAUSE_TICKS (PAUSE_TICKS),
        .PIPE_COMP   (PIPE_COMP)
    ) u_asm (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .ks_bit      (ks_bit),
        .last_pause  (last_pause),
        .frame_valid (frame_valid),
        .frame_error (frame_error),
        .frame_len   (frame_len),
        .frame_data  (frame_data),
        .end_ts      (end_ts)
    );

    assign ks_adv = evt.adv | evt.bit_vld;

    // R6: the keystream is never stepped while an outcome is reported
    a_r6_no_adv_on_result: assert property (@(posedge clk) disable iff (rst)
        evt.hunt_fail |-> !ks_adv);
endmodule

// File: tb/ppr_frame_rx_test.sv
`timescale 1ns/1ps
module ppr_frame_rx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        env = 1'b1;
    logic        tick = 1'b0;
    logic        arm = 1'b0;
    logic        ks_bit;
    logic        ks_adv;
    logic        frame_valid, frame_error;
    logic [4:0]  frame_len;
    logic [22:0] frame_data;
    logic [31:0] end_ts;

    int checks = 0;
    int fails  = 0;
    int tidx   = 0;
    int acnt;
    int lens [0:31];

    always #2.5 clk = ~clk;

    ppr_frame_rx uut (
        .clk(clk), .rst(rst), .env_in(env), .tick(tick), .arm(arm),
        .ks_bit(ks_bit), .ks_adv(ks_adv), .frame_valid(frame_valid),
        .frame_error(frame_error), .frame_len(frame_len),
        .frame_data(frame_data), .end_ts(end_ts)
    );

    function automatic logic kfun(input int n);
        logic [7:0] v;
        v = 8'(n * 29 + 7);
        return ^(v & 8'hB3);
    endfunction

    always_ff @(posedge clk) begin
        if (rst)         acnt <= 0;
        else if (ks_adv) acnt <= acnt + 1;
    end
    assign ks_bit = kfun(acnt);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic lvl);
        env  = lvl;
        tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        tidx++;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // kind 0: final pause then long pulse; 1: short bit; 2: pause held low
    task automatic run_frame(input int n, input int g, input int kind, input bit mid_arm);
        int base, a0, fstart, got, exp_done, exp_ts, nst;
        logic [22:0] exp_d;
        bit lvl;
        base = acnt;
        do_arm();
        chk("R9 clear on arm", frame_data, 0);
        a0 = base + 1 + g / 21;
        repeat (g) step(1'b1);
        exp_d = '0;
        for (int j = 0; j < n; j++) begin
            int pw;
            pw = (lens[j] > 8) ? 4 : 2;
            repeat (pw) step(1'b0);
            repeat (lens[j] - pw) step(1'b1);
            if (j < 23) exp_d[j] = (lens[j] > 17) ^ kfun(a0 + j);
            if (mid_arm && j == 2) do_arm();
        end
        fstart = tidx;
        got = -1;
        for (int s = 0; s < 80; s++) begin
            if (kind == 0)      lvl = (s >= 4);
            else if (kind == 1) lvl = !(s == 0 || s == 3);
            else                lvl = 1'b0;
            step(lvl);
            if (frame_valid || frame_error) begin
                got = tidx - 1;
                break;
            end
        end
        exp_done = (kind == 1) ? fstart + 3 : fstart + 32;
        exp_ts   = (kind == 1) ? fstart + 5 : fstart + 2;
        chk(kind == 1 ? "R3 short-bit end tick" : "R4 window end tick", got, exp_done);
        chk("R5 valid flag", frame_valid, (n >= 6 && n <= 23));
        chk("R5 error flag", frame_error, !(n >= 6 && n <= 23));
        chk("R10 length", frame_len, (n > 24) ? 24 : n);
        chk("R6 descrambled data", frame_data, exp_d);
        chk("R8 end timestamp", end_ts, exp_ts);
        chk("R6 keystream steps", acnt, a0 + n);
        @(negedge clk);
        chk("R9 pulse width", {frame_valid, frame_error}, 0);
        nst = 0;
        repeat (3) step(1'b1);
        chk("R9 held data", frame_data, exp_d);
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", frame_valid, 0);
        chk("R1 error", frame_error, 0);
        chk("R1 len", frame_len, 0);
        chk("R1 data", frame_data, 0);
        chk("R1 ts", end_ts, 0);
        chk("R1 adv", ks_adv, 0);

        // R2 R5 R6 length sweep with varied patterns and hunt gaps (R7)
        for (int n = 6; n <= 23; n++) begin
            for (int j = 0; j < n; j++)
                lens[j] = (((n * 7 + j * 5) >> 1) & 1) ? 21 : 13;
            run_frame(n, (n * 13) % 50, 0, 1'b0);
        end

        // R2 interval sweep: 4..17 decode as 0, 18..31 as 1
        for (int j = 0; j < 14; j++) lens[j] = 4 + j;
        run_frame(14, 3, 0, 1'b0);
        for (int j = 0; j < 14; j++) lens[j] = 18 + j;
        run_frame(14, 22, 0, 1'b0);

        // R5 R10 too short and too long frames
        for (int j = 0; j < 32; j++) lens[j] = (j % 3 == 0) ? 21 : 13;
        run_frame(5, 0, 0, 1'b0);
        run_frame(24, 1, 0, 1'b0);
        run_frame(25, 2, 0, 1'b0);

        // R3 short-bit ending, R4 pause held too long
        run_frame(7, 4, 1, 1'b0);
        run_frame(6, 5, 2, 1'b0);

        // R9 arm during reception ignored; R7 two hunt periods
        run_frame(10, 45, 0, 1'b1);

        // R7 hunt give-up
        begin
            int base;
            bit early;
            base = acnt;
            early = 1'b0;
            do_arm();
            for (int s = 0; s < 839; s++) begin
                step(1'b1);
                if (frame_valid || frame_error) early = 1'b1;
            end
            chk("R7 no early outcome", early, 0);
            step(1'b1);
            chk("R7 hunt error", frame_error, 1);
            chk("R7 hunt valid", frame_valid, 0);
            chk("R7 hunt len", frame_len, 0);
            chk("R7 hunt advances", acnt, base + 40);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule